// File: doc/BRIEF.md
# Boot-Select and Remap Address Decoder

This block turns one bus master's address into a one-hot slave select. Every master on the interconnect gets its own copy. The lowest megabyte of the address space is a boot window, and one of three slaves answers it. Which one depends on two things: a boot-mode level captured while reset is held, and a sticky remap flag. Before remap, the window reaches internal non-volatile memory when the captured level is 0 and external non-volatile memory when it is 1. Once a remap strobe has been seen, the window reaches internal SRAM instead. Software uses this to place exception vectors in writable memory.

Each memory also has a fixed region of its own that it answers whatever the boot and remap state. A fourth slave, a peripheral space, sits at the top of the map. A valid address that falls in no region selects nothing and raises an error flag. The select and the error flag are combinational from the address. The captured boot level and the remap flag are registers.

Top module: `boot_remap_decoder`

## Requirements
- R1: While `rst` is high at a rising clock edge, the remap flag is cleared and the level of `boot_pin` is captured, even if `remap_req` is high at the same time.
- R2: With a captured boot level of 0 and no remap, a valid address in 0x0000_0000..0x000F_FFFF drives `slave_sel` = 4'b0001 (internal non-volatile memory).
- R3: With a captured boot level of 1 and no remap, a valid address in the boot window drives `slave_sel` = 4'b0010 (external non-volatile memory).
- R4: Changes of `boot_pin` after reset is released have no effect on routing until the next reset.
- R5: When `remap_req` is high at a rising edge outside reset, the boot window drives `slave_sel` = 4'b0100 (SRAM) from the following cycle on. Before that edge the boot window is not yet remapped.
- R6: The remap flag stays set whatever `remap_req` does afterwards. Only reset clears it.
- R7: These fixed regions select their slave in every boot and remap state: 0x0010_0000..0x001F_FFFF gives 4'b0001, 0x0020_0000..0x002F_FFFF gives 4'b0100, 0x1000_0000..0x1FFF_FFFF gives 4'b0010, and 0xF000_0000..0xFFFF_FFFF gives 4'b1000 (peripherals).
- R8: A valid address outside every region gives `slave_sel` = 0 with `addr_err` = 1.
- R9: While `addr_valid` is low, `slave_sel` = 0 and `addr_err` = 0.
- R10: `slave_sel` and `addr_err` follow a change of `addr` in the same cycle, with no clock edge in between.
- R11: At most one bit of `slave_sel` is ever set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; captures `boot_pin` |
| boot_pin | input | 1 | Boot-mode level: 0 selects internal, 1 selects external non-volatile memory |
| remap_req | input | 1 | Remap command strobe; sets the sticky remap flag |
| addr_valid | input | 1 | Address qualifier |
| addr | input | 32 | Master byte address |
| slave_sel | output | 4 | One-hot select: bit0 internal NVM, bit1 external NVM, bit2 SRAM, bit3 peripherals |
| addr_err | output | 1 | Valid address hit no region |

## Verification
The hardest state to reach from the ports is a boot window routed to external memory while the pin reads the opposite level. It must also stay unremapped even though a remap strobe was seen during reset. The stimulus holds `remap_req` high across a second reset with `boot_pin` at 1. It flips the pin the moment reset drops, then probes the boot window before any new strobe. The boot-window probe made in the same cycle as the strobe, before the edge, shows that remap takes effect exactly one edge later.

// File: rtl/boot_map_pkg.sv
package boot_map_pkg;

    localparam int ADDR_W  = 32;
    localparam int NUM_SLV = 4;
    localparam int NUM_RGN = 5;

    typedef enum logic [1:0] {
        SLV_INT_NVM = 2'd0,
        SLV_EXT_NVM = 2'd1,
        SLV_SRAM    = 2'd2,
        SLV_PERIPH  = 2'd3
    } slave_e;

    // Region index 0 is the boot window; a lower index wins on overlap.
    typedef enum int {
        RGN_BOOT    = 0,
        RGN_INT_NVM = 1,
        RGN_SRAM    = 2,
        RGN_EXT_NVM = 3,
        RGN_PERIPH  = 4
    } region_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] mask;   // size - 1, power-of-two aligned
        slave_e            slave;  // ignored for the boot window
    } region_t;

    typedef struct packed {
        logic remapped;
        logic boot_ext;
    } boot_state_t;

    function automatic region_t region_desc(input int idx);
        region_t d;
        case (idx)
            RGN_BOOT:    d = '{base: 32'h0000_0000, mask: 32'h000F_FFFF, slave: SLV_INT_NVM};
            RGN_INT_NVM: d = '{base: 32'h0010_0000, mask: 32'h000F_FFFF, slave: SLV_INT_NVM};
            RGN_SRAM:    d = '{base: 32'h0020_0000, mask: 32'h000F_FFFF, slave: SLV_SRAM};
            RGN_EXT_NVM: d = '{base: 32'h1000_0000, mask: 32'h0FFF_FFFF, slave: SLV_EXT_NVM};
            default:     d = '{base: 32'hF000_0000, mask: 32'h0FFF_FFFF, slave: SLV_PERIPH};
        endcase
        return d;
    endfunction

    function automatic slave_e boot_target(input boot_state_t st);
        if (st.remapped)
            return SLV_SRAM;
        else if (st.boot_ext)
            return SLV_EXT_NVM;
        else
            return SLV_INT_NVM;
    endfunction

    function automatic logic [NUM_SLV-1:0] slave_onehot(input slave_e s);
        logic [NUM_SLV-1:0] v;
        v = '0;
        v[s] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/boot_mode_latch.sv
module boot_mode_latch
    import boot_map_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        boot_pin,
    input  logic        remap_req,
    output boot_state_t boot_st
);

    always_ff @(posedge clk) begin
        if (rst) begin
            boot_st.boot_ext <= boot_pin;
            boot_st.remapped <= 1'b0;
        end else if (remap_req) begin
            boot_st.remapped <= 1'b1;
        end
    end

endmodule

// File: rtl/boot_region_match.sv
module boot_region_match #(
    parameter int            AW   = 32,
    parameter logic [AW-1:0] BASE = '0,
    parameter logic [AW-1:0] MASK = '0
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);

    localparam logic [AW-1:0] KEEP = ~MASK;

    assign hit = ((addr & KEEP) == BASE);

endmodule

// File: rtl/boot_slave_route.sv
module boot_slave_route
    import boot_map_pkg::*;
#(
    parameter int NRGN = NUM_RGN,
    parameter int NSLV = NUM_SLV
) (
    input  logic            addr_valid,
    input  logic [NRGN-1:0] rgn_hit,
    input  boot_state_t     boot_st,
    output logic [NSLV-1:0] slave_sel,
    output logic            addr_err
);

    slave_e target;
    logic   found;

    always_comb begin
        target = SLV_INT_NVM;
        found  = 1'b0;
        // Walk from the highest index down so the lowest matching index wins.
        for (int i = NRGN - 1; i >= 0; i--) begin
            if (rgn_hit[i]) begin
                found = 1'b1;
                if (i == RGN_BOOT)
                    target = boot_target(boot_st);
                else
                    target = region_desc(i).slave;
            end
        end
    end

    always_comb begin
        slave_sel = '0;
        addr_err  = 1'b0;
        if (addr_valid) begin
            if (found)
                slave_sel = slave_onehot(target);
            else
                addr_err = 1'b1;
        end
    end

endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
    import boot_map_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               boot_pin,
    input  logic               remap_req,
    input  logic               addr_valid,
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_SLV-1:0] slave_sel,
    output logic               addr_err
);

    boot_state_t        boot_st;
    logic [NUM_RGN-1:0] rgn_hit;

    boot_mode_latch u_state (
        .clk       (clk),
        .rst       (rst),
        .boot_pin  (boot_pin),
        .remap_req (remap_req),
        .boot_st   (boot_st)
    );

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
        localparam region_t DESC = region_desc(g);
        boot_region_match #(
            .AW   (ADDR_W),
            .BASE (DESC.base),
            .MASK (DESC.mask)
        ) u_match (
            .addr (addr),
            .hit  (rgn_hit[g])
        );
    end

    boot_slave_route #(
        .NRGN (NUM_RGN),
        .NSLV (NUM_SLV)
    ) u_route (
        .addr_valid (addr_valid),
        .rgn_hit    (rgn_hit),
        .boot_st    (boot_st),
        .slave_sel  (slave_sel),
        .addr_err   (addr_err)
    );

endmodule

// File: rtl/boot_remap_decoder_chk.sv
module boot_remap_decoder_chk
    import boot_map_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               boot_pin,
    input logic               remap_req,
    input logic               addr_valid,
    input logic [ADDR_W-1:0]  addr,
    input logic [NUM_SLV-1:0] slave_sel,
    input logic               addr_err,
    input boot_state_t        boot_st
);

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slave_sel)); // R11

    AST_ERR_NO_SEL: assert property (@(posedge clk) disable iff (rst)
        addr_err |-> (slave_sel == '0)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !addr_valid |-> (slave_sel == '0 && !addr_err)); // R9

    AST_BOOT_HELD: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(boot_st.boot_ext)); // R4

    AST_REMAP_SET: assert property (@(posedge clk) disable iff (rst)
        remap_req |=> boot_st.remapped); // R5

    AST_REMAP_STICKY: assert property (@(posedge clk) disable iff (rst)
        boot_st.remapped |=> boot_st.remapped); // R6

    AST_BOOT_TO_SRAM: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && addr[31:20] == '0 && boot_st.remapped)
            |-> (slave_sel == 4'b0100)); // R5

endmodule

bind boot_remap_decoder boot_remap_decoder_chk u_chk (.*);

// File: tb/boot_remap_decoder_tb.sv
module boot_remap_decoder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;

    // {addr[31:0], valid, exp_sel[3:0], exp_err}
    localparam logic [37:0] VECS [NVEC] = '{
        {32'h0010_0000, 1'b1, 4'b0001, 1'b0},
        {32'h001F_FFFC, 1'b1, 4'b0001, 1'b0},
        {32'h0020_0000, 1'b1, 4'b0100, 1'b0},
        {32'h002F_FFFF, 1'b1, 4'b0100, 1'b0},
        {32'h1000_0000, 1'b1, 4'b0010, 1'b0},
        {32'h1FFF_FFFF, 1'b1, 4'b0010, 1'b0},
        {32'hF000_0000, 1'b1, 4'b1000, 1'b0},
        {32'hFFFF_FFFF, 1'b1, 4'b1000, 1'b0},
        {32'h0030_0000, 1'b1, 4'b0000, 1'b1},
        {32'h0FFF_FFFF, 1'b1, 4'b0000, 1'b1},
        {32'h2000_0000, 1'b1, 4'b0000, 1'b1},
        {32'hEFFF_FFFF, 1'b1, 4'b0000, 1'b1},
        {32'h0020_0000, 1'b0, 4'b0000, 1'b0},
        {32'h0000_0000, 1'b0, 4'b0000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boot_pin = 1'b0;
    logic        remap_req = 1'b0;
    logic        addr_valid = 1'b0;
    logic [31:0] addr = '0;
    logic [3:0]  slave_sel;
    logic        addr_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_remap_decoder dut_i (
        .clk        (clk),
        .rst        (rst),
        .boot_pin   (boot_pin),
        .remap_req  (remap_req),
        .addr_valid (addr_valid),
        .addr       (addr),
        .slave_sel  (slave_sel),
        .addr_err   (addr_err)
    );

    task automatic check(input string req, input logic [3:0] exp_sel, input logic exp_err);
        checks++;
        if (slave_sel !== exp_sel || addr_err !== exp_err) begin
            errors++;
            $display("FAIL %s addr=%h sel=%b err=%b expected sel=%b err=%b",
                     req, addr, slave_sel, addr_err, exp_sel, exp_err);
        end
        checks++;
        if ($countones(slave_sel) > 1) begin
            errors++;
            $display("FAIL R11 sel=%b expected at most one bit", slave_sel);
        end
    endtask

    task automatic probe(input logic [31:0] a, input logic v, input string req,
                         input logic [3:0] exp_sel, input logic exp_err);
        addr = a;
        addr_valid = v;
        #1;
        check(req, exp_sel, exp_err);
    endtask

    task automatic do_reset(input logic pin, input logic remap_lvl);
        @(negedge clk);
        rst = 1'b1;
        boot_pin = pin;
        remap_req = remap_lvl;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        remap_req = 1'b0;
        boot_pin = ~pin;  // flip at once: the captured level must not follow (R4)
    endtask

    task automatic walk_table();
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            if (!VECS[i][5])
                probe(VECS[i][37:6], 1'b0, "R9", VECS[i][4:1], VECS[i][0]);
            else if (VECS[i][0])
                probe(VECS[i][37:6], 1'b1, "R8", VECS[i][4:1], VECS[i][0]);
            else
                probe(VECS[i][37:6], 1'b1, "R7", VECS[i][4:1], VECS[i][0]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // Reset with boot level 0: boot window to internal NVM
        do_reset(1'b0, 1'b0);
        @(negedge clk);
        probe(32'h0000_0100, 1'b1, "R1", 4'b0001, 1'b0);
        probe(32'h000F_FFFF, 1'b1, "R2", 4'b0001, 1'b0);
        repeat (3) @(negedge clk);
        probe(32'h0000_0000, 1'b1, "R4", 4'b0001, 1'b0);

        // Fixed regions, errors and idle before remap
        walk_table();

        // R10: address change mid-cycle, no edge between
        @(negedge clk);
        probe(32'h1000_0040, 1'b1, "R10", 4'b0010, 1'b0);
        probe(32'h0400_0000, 1'b1, "R10", 4'b0000, 1'b1);
        probe(32'hF000_1000, 1'b1, "R10", 4'b1000, 1'b0);

        // Remap strobe: not effective before the edge, effective after (R5)
        @(negedge clk);
        remap_req = 1'b1;
        probe(32'h0000_0200, 1'b1, "R5", 4'b0001, 1'b0);
        @(negedge clk);
        remap_req = 1'b0;
        probe(32'h0000_0200, 1'b1, "R5", 4'b0100, 1'b0);

        // Sticky: idle cycles and a second strobe do not clear (R6)
        repeat (4) @(negedge clk);
        probe(32'h0008_0000, 1'b1, "R6", 4'b0100, 1'b0);
        remap_req = 1'b1;
        @(negedge clk);
        remap_req = 1'b0;
        repeat (2) @(negedge clk);
        probe(32'h0000_0000, 1'b1, "R6", 4'b0100, 1'b0);

        // Fixed regions unchanged after remap
        walk_table();

        // Reset with boot level 1 while remap_req is held: remap cleared (R1)
        do_reset(1'b1, 1'b1);
        @(negedge clk);
        probe(32'h0000_0000, 1'b1, "R1", 4'b0010, 1'b0);
        probe(32'h000F_FFF0, 1'b1, "R3", 4'b0010, 1'b0);
        boot_pin = 1'b1;
        repeat (2) @(negedge clk);
        boot_pin = 1'b0;
        repeat (2) @(negedge clk);
        probe(32'h0001_0000, 1'b1, "R4", 4'b0010, 1'b0);
        probe(32'h0010_0000, 1'b1, "R7", 4'b0001, 1'b0);

        // Remap from external boot
        remap_req = 1'b1;
        @(negedge clk);
        remap_req = 1'b0;
        probe(32'h0001_0000, 1'b1, "R5", 4'b0100, 1'b0);
        probe(32'h1000_0000, 1'b1, "R7", 4'b0010, 1'b0);
        probe(32'h0001_0000, 1'b0, "R9", 4'b0000, 1'b0);

        // Reset again clears remap (R6)
        do_reset(1'b0, 1'b0);
        @(negedge clk);
        probe(32'h0000_0010, 1'b1, "R6", 4'b0001, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule